// File: doc/BRIEF.md
# Fixed-Latency Register Slave

This block is a small bank of word registers that sits behind an upstream bus adapter. The adapter has already reduced the memory-mapped protocol to single-beat transfers, so the slave sees no IDs, no bursts and no handshake. A write is one strobe that carries address, data, byte strobes, size and protection together. A read is one strobe that carries address, size and protection.

The slave is always ready. It has no ready outputs and no ready inputs, and there is no state machine. Each response is the request strobe delayed by one register stage. Read data is captured on the clock edge that sees the request, so it comes out together with its valid. The size field and the low address bits choose the byte lanes of a narrow access. Two protection masks, set by parameters, let an integration refuse some writes or blank some reads. Both masks default to zero, which leaves protection without effect.

Top module: `lite_regfile_slave`

## Requirements
- R1: A write takes place on every clock edge where `wr_vld` is high, using the inputs present at that edge. Register k (k = 0..NUM_REGS-1) sits at byte offset 4*k and is selected by `wr_addr[3:2]`. A write whose `wr_addr[ADDR_W-1:2]` is NUM_REGS or more changes no register.
- R2: A write updates byte lane i (bits 8i+7..8i) only when `wr_strb[i]` is 1 and lane i lies inside the access window. The window covers 2^size bytes and holds every lane i with (i >> size) == (addr[1:0] >> size). A size of 2 or more covers all four lanes.
- R3: `wr_rsp_vld` equals `wr_vld` delayed by exactly one clock. The block has no ready outputs.
- R4: `rd_rsp_vld` equals `rd_vld` delayed by exactly one clock. `rd_data` is captured at the request edge. Reads on consecutive cycles each return their own data. A read in the same cycle as a write to the same register returns the contents from before that write.
- R5: `rd_last` is high exactly when `rd_rsp_vld` is high.
- R6: `wr_rsp` and `rd_rsp` are OKAY (2'b00) on every response.
- R7: A read whose `rd_addr[ADDR_W-1:2]` is NUM_REGS or more returns zero with OKAY. For a narrow read, the lanes outside the size window read as zero.
- R8: A write is dropped when (`wr_prot` & WR_PROT_MASK) is nonzero, but it still gets an OKAY response. A read returns zero when (`rd_prot` & RD_PROT_MASK) is nonzero. Protection bits outside the mask have no effect.
- R9: While `rst_n` is low at a clock edge, all registers, `rd_data` and both response valids clear to zero on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_vld | input | 1 | Shared write address/data strobe |
| wr_addr | input | ADDR_W | Write byte address |
| wr_data | input | DATA_W | Write data |
| wr_strb | input | DATA_W/8 | Write byte strobes |
| wr_size | input | 3 | Write size, log2 of bytes |
| wr_prot | input | 3 | Write protection attributes |
| wr_rsp_vld | output | 1 | Write response valid |
| wr_rsp | output | 2 | Write response code |
| rd_vld | input | 1 | Read request strobe |
| rd_addr | input | ADDR_W | Read byte address |
| rd_size | input | 3 | Read size, log2 of bytes |
| rd_prot | input | 3 | Read protection attributes |
| rd_rsp_vld | output | 1 | Read data valid |
| rd_data | output | DATA_W | Read data |
| rd_rsp | output | 2 | Read response code |
| rd_last | output | 1 | Last beat flag |

## Verification
The bench builds the block with DATA_W=32, ADDR_W=8, NUM_REGS=4, WR_PROT_MASK=3'b100 and RD_PROT_MASK=3'b010. The nonzero masks let the bench reach the dropped-write and blanked-read paths. They also let it show that protection bits outside the masks change nothing. With eight address bits, the bench can issue out-of-range accesses at 0x10 and above, next to in-range ones.

// File: rtl/lrs_pkg.sv
package lrs_pkg;
  localparam int SIZE_W = 3;
  localparam int PROT_W = 3;

  typedef enum logic [1:0] {
    RSP_OKAY   = 2'b00,
    RSP_EXOKAY = 2'b01,
    RSP_SLVERR = 2'b10,
    RSP_DECERR = 2'b11
  } bus_resp_e;
endpackage

// File: rtl/lrs_addr_dec.sv
module lrs_addr_dec #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 4,
  localparam int NB      = DATA_W / 8,
  localparam int LSB     = $clog2(NB),
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic [ADDR_W-1:0]          addr,
  input  logic [lrs_pkg::SIZE_W-1:0] size,
  output logic [IDX_W-1:0]           idx,
  output logic                       in_range,
  output logic [NB-1:0]              lane_win
);

  function automatic logic word_in_map(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] word;
    word = a >> LSB;
    return word < ADDR_W'(NUM_REGS);
  endfunction

  function automatic logic [NB-1:0] window(input logic [lrs_pkg::SIZE_W-1:0] sz,
                                           input logic [LSB-1:0] low);
    logic [NB-1:0] w;
    for (int i = 0; i < NB; i++) begin
      if (int'(sz) >= LSB) w[i] = 1'b1;
      else                 w[i] = ((LSB'(i) ^ low) >> sz) == '0;
    end
    return w;
  endfunction

  assign idx      = addr[LSB +: IDX_W];
  assign in_range = word_in_map(addr);
  assign lane_win = window(size, addr[LSB-1:0]);

endmodule

// File: rtl/lrs_reg_bank.sv
module lrs_reg_bank #(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 4,
  localparam int NB      = DATA_W / 8,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_go,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic [NB-1:0]              wr_lanes,
  output logic [NUM_REGS*DATA_W-1:0] regs_flat,
  output logic [NUM_REGS-1:0]        hit_vec
);

  function automatic logic [DATA_W-1:0] merge(input logic [DATA_W-1:0] old_w,
                                              input logic [DATA_W-1:0] new_w,
                                              input logic [NB-1:0]     lanes);
    logic [DATA_W-1:0] r;
    r = old_w;
    for (int b = 0; b < NB; b++)
      if (lanes[b]) r[8*b +: 8] = new_w[8*b +: 8];
    return r;
  endfunction

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic [DATA_W-1:0] q;

    assign hit_vec[r] = wr_go && (wr_idx == IDX_W'(r));

    always_ff @(posedge clk) begin
      if (!rst_n)          q <= '0;
      else if (hit_vec[r]) q <= merge(q, wr_data, wr_lanes);
    end

    assign regs_flat[r*DATA_W +: DATA_W] = q;
  end

endmodule

// File: rtl/lrs_rd_path.sv
module lrs_rd_path #(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 4,
  localparam int NB      = DATA_W / 8,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rd_go,
  input  logic [IDX_W-1:0]           rd_idx,
  input  logic                       rd_keep,
  input  logic [NB-1:0]              rd_lanes,
  input  logic [NUM_REGS*DATA_W-1:0] regs_flat,
  output logic [DATA_W-1:0]          rd_data
);

  function automatic logic [DATA_W-1:0] keep_lanes(input logic [DATA_W-1:0] w,
                                                   input logic [NB-1:0]     lanes);
    logic [DATA_W-1:0] r;
    for (int b = 0; b < NB; b++)
      r[8*b +: 8] = lanes[b] ? w[8*b +: 8] : 8'h00;
    return r;
  endfunction

  logic [DATA_W-1:0] sel_word;
  logic [DATA_W-1:0] next_data;

  always_comb begin
    sel_word = '0;
    for (int r = 0; r < NUM_REGS; r++)
      if (rd_idx == IDX_W'(r)) sel_word = regs_flat[r*DATA_W +: DATA_W];
  end

  assign next_data = rd_keep ? keep_lanes(sel_word, rd_lanes) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_go) rd_data <= next_data;
  end

endmodule

// File: rtl/lrs_resp_pipe.sv
module lrs_resp_pipe (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_vld,
  input  logic             rd_vld,
  output logic             wr_rsp_vld,
  output lrs_pkg::bus_resp_e wr_rsp,
  output logic             rd_rsp_vld,
  output lrs_pkg::bus_resp_e rd_rsp,
  output logic             rd_last
);
  import lrs_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_rsp_vld <= 1'b0;
      wr_rsp     <= RSP_OKAY;
    end else begin
      wr_rsp_vld <= wr_vld;
      wr_rsp     <= RSP_OKAY;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_rsp_vld <= 1'b0;
      rd_last    <= 1'b0;
      rd_rsp     <= RSP_OKAY;
    end else begin
      rd_rsp_vld <= rd_vld;
      rd_last    <= rd_vld;
      rd_rsp     <= RSP_OKAY;
    end
  end

endmodule

// File: rtl/lite_regfile_slave.sv
module lite_regfile_slave #(
  parameter int       DATA_W       = 32,
  parameter int       ADDR_W       = 8,
  parameter int       NUM_REGS     = 4,
  parameter bit [2:0] WR_PROT_MASK = 3'b000,
  parameter bit [2:0] RD_PROT_MASK = 3'b000,
  localparam int      NB           = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_vld,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [NB-1:0]     wr_strb,
  input  logic [2:0]        wr_size,
  input  logic [2:0]        wr_prot,
  output logic              wr_rsp_vld,
  output logic [1:0]        wr_rsp,
  input  logic              rd_vld,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [2:0]        rd_size,
  input  logic [2:0]        rd_prot,
  output logic              rd_rsp_vld,
  output logic [DATA_W-1:0] rd_data,
  output logic [1:0]        rd_rsp,
  output logic              rd_last
);
  import lrs_pkg::*;

  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [IDX_W-1:0]           wr_idx, rd_idx;
  logic                       wr_in_range, rd_in_range;
  logic [NB-1:0]              wr_win, rd_win;
  logic                       wr_blocked, rd_blocked;
  logic                       wr_go;
  logic [NB-1:0]              wr_lane_en;
  logic [NUM_REGS-1:0]        wr_hit_vec;
  logic [NUM_REGS*DATA_W-1:0] regs_flat;
  bus_resp_e                  wr_rsp_e, rd_rsp_e;

  lrs_addr_dec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_wr_dec (
    .addr(wr_addr), .size(wr_size),
    .idx(wr_idx), .in_range(wr_in_range), .lane_win(wr_win)
  );

  lrs_addr_dec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_rd_dec (
    .addr(rd_addr), .size(rd_size),
    .idx(rd_idx), .in_range(rd_in_range), .lane_win(rd_win)
  );

  assign wr_blocked = (wr_prot & WR_PROT_MASK) != 3'b000;
  assign rd_blocked = (rd_prot & RD_PROT_MASK) != 3'b000;
  assign wr_go      = wr_vld && wr_in_range && !wr_blocked;
  assign wr_lane_en = wr_strb & wr_win;

  lrs_reg_bank #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_go(wr_go), .wr_idx(wr_idx), .wr_data(wr_data), .wr_lanes(wr_lane_en),
    .regs_flat(regs_flat), .hit_vec(wr_hit_vec)
  );

  lrs_rd_path #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_rd (
    .clk(clk), .rst_n(rst_n),
    .rd_go(rd_vld), .rd_idx(rd_idx), .rd_keep(rd_in_range && !rd_blocked),
    .rd_lanes(rd_win), .regs_flat(regs_flat), .rd_data(rd_data)
  );

  lrs_resp_pipe u_resp (
    .clk(clk), .rst_n(rst_n), .wr_vld(wr_vld), .rd_vld(rd_vld),
    .wr_rsp_vld(wr_rsp_vld), .wr_rsp(wr_rsp_e),
    .rd_rsp_vld(rd_rsp_vld), .rd_rsp(rd_rsp_e), .rd_last(rd_last)
  );

  assign wr_rsp = wr_rsp_e;
  assign rd_rsp = rd_rsp_e;

endmodule

// File: rtl/lrs_chk.sv
module lrs_chk #(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_vld,
  input logic                rd_vld,
  input logic                wr_rsp_vld,
  input logic [1:0]          wr_rsp,
  input logic                rd_rsp_vld,
  input logic [1:0]          rd_rsp,
  input logic                rd_last,
  input logic [DATA_W-1:0]   rd_data,
  input logic [NUM_REGS-1:0] wr_hit_vec,
  input logic                wr_blocked,
  input logic                rd_in_range,
  input logic                rd_blocked
);

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(wr_hit_vec)); // R1
  AST_HIT_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n) (wr_hit_vec != '0) |-> wr_vld); // R1
  AST_WR_ECHO: assert property (@(posedge clk) disable iff (!rst_n) wr_vld |=> wr_rsp_vld); // R3
  AST_WR_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !wr_vld |=> !wr_rsp_vld); // R3
  AST_RD_ECHO: assert property (@(posedge clk) disable iff (!rst_n) rd_vld |=> rd_rsp_vld); // R4
  AST_RD_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !rd_vld |=> !rd_rsp_vld); // R4
  AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n) rd_rsp_vld |-> rd_last); // R5
  AST_LAST_ONLY_VALID: assert property (@(posedge clk) disable iff (!rst_n) rd_last |-> rd_rsp_vld); // R5
  AST_WR_OKAY: assert property (@(posedge clk) disable iff (!rst_n) wr_rsp_vld |-> (wr_rsp == 2'b00)); // R6
  AST_RD_OKAY: assert property (@(posedge clk) disable iff (!rst_n) rd_rsp_vld |-> (rd_rsp == 2'b00)); // R6
  AST_MISS_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (rd_vld && !rd_in_range) |=> (rd_data == '0)); // R7
  AST_PROT_DROP: assert property (@(posedge clk) disable iff (!rst_n) (wr_vld && wr_blocked) |-> (wr_hit_vec == '0)); // R8
  AST_PROT_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (rd_vld && rd_blocked) |=> (rd_data == '0)); // R8
  AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> (!wr_rsp_vld && !rd_rsp_vld && rd_data == '0)); // R9

endmodule

bind lite_regfile_slave lrs_chk #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_vld(wr_vld), .rd_vld(rd_vld),
  .wr_rsp_vld(wr_rsp_vld), .wr_rsp(wr_rsp),
  .rd_rsp_vld(rd_rsp_vld), .rd_rsp(rd_rsp), .rd_last(rd_last), .rd_data(rd_data),
  .wr_hit_vec(wr_hit_vec), .wr_blocked(wr_blocked),
  .rd_in_range(rd_in_range), .rd_blocked(rd_blocked)
);

// File: tb/lite_regfile_slave_tb_top.sv
module lite_regfile_slave_tb_top;
  localparam int DW = 32;
  localparam int AW = 8;
  localparam int NR = 4;
  localparam bit [2:0] WMASK = 3'b100;
  localparam bit [2:0] RMASK = 3'b010;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_vld = 1'b0, rd_vld = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [3:0] wr_strb = '0;
  logic [2:0] wr_size = 3'd2, wr_prot = '0, rd_size = 3'd2, rd_prot = '0;
  logic wr_rsp_vld, rd_rsp_vld, rd_last;
  logic [1:0] wr_rsp, rd_rsp;
  logic [DW-1:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [DW-1:0] model [NR];

  always #4 clk = ~clk;

  lite_regfile_slave #(.DATA_W(DW), .ADDR_W(AW), .NUM_REGS(NR),
                       .WR_PROT_MASK(WMASK), .RD_PROT_MASK(RMASK)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .wr_vld(wr_vld), .wr_addr(wr_addr), .wr_data(wr_data), .wr_strb(wr_strb),
    .wr_size(wr_size), .wr_prot(wr_prot), .wr_rsp_vld(wr_rsp_vld), .wr_rsp(wr_rsp),
    .rd_vld(rd_vld), .rd_addr(rd_addr), .rd_size(rd_size), .rd_prot(rd_prot),
    .rd_rsp_vld(rd_rsp_vld), .rd_data(rd_data), .rd_rsp(rd_rsp), .rd_last(rd_last)
  );

  task automatic check(input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Lanes a narrow access covers: bytes = 2^size starting at the aligned base.
  function automatic logic [3:0] lanes_of(input logic [2:0] size, input logic [1:0] low);
    int bytes, base;
    logic [3:0] m;
    bytes = (size >= 3'd2) ? 4 : (1 << size);
    base  = (int'(low) / bytes) * bytes;
    m = '0;
    for (int i = 0; i < 4; i++) if (i >= base && i < base + bytes) m[i] = 1'b1;
    return m;
  endfunction

  function automatic logic [DW-1:0] expect_read(input logic [AW-1:0] a,
                                                input logic [2:0] size, input logic [2:0] prot);
    logic [3:0] m;
    logic [DW-1:0] w;
    if (a >= 8'h10 || (prot & RMASK) != 0) return '0;
    m = lanes_of(size, a[1:0]);
    w = model[a[3:2]];
    for (int i = 0; i < 4; i++) if (!m[i]) w[8*i +: 8] = 8'h00;
    return w;
  endfunction

  task automatic model_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                             input logic [3:0] s, input logic [2:0] size, input logic [2:0] prot);
    logic [3:0] m;
    if (a >= 8'h10 || (prot & WMASK) != 0) return;
    m = s & lanes_of(size, a[1:0]);
    for (int i = 0; i < 4; i++) if (m[i]) model[a[3:2]][8*i +: 8] = d[8*i +: 8];
  endtask

  task automatic do_write(input string req, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input logic [3:0] s, input logic [2:0] size, input logic [2:0] prot);
    @(negedge clk);
    wr_vld = 1'b1; wr_addr = a; wr_data = d; wr_strb = s; wr_size = size; wr_prot = prot;
    @(negedge clk);
    wr_vld = 1'b0;
    check("R3", "wr_rsp_vld after write", DW'(wr_rsp_vld), 32'd1);
    check("R6", "wr_rsp code", DW'(wr_rsp), 32'd0);
    model_write(a, d, s, size, prot);
    if (req != "") check(req, "write response present", DW'(wr_rsp_vld), 32'd1);
  endtask

  task automatic do_read(input string req, input logic [AW-1:0] a,
                         input logic [2:0] size, input logic [2:0] prot);
    logic [DW-1:0] exp;
    exp = expect_read(a, size, prot);
    @(negedge clk);
    rd_vld = 1'b1; rd_addr = a; rd_size = size; rd_prot = prot;
    @(negedge clk);
    rd_vld = 1'b0;
    check("R4", "rd_rsp_vld after read", DW'(rd_rsp_vld), 32'd1);
    check("R5", "rd_last with valid", DW'(rd_last), 32'd1);
    check("R6", "rd_rsp code", DW'(rd_rsp), 32'd0);
    check(req, $sformatf("rd_data at %h", a), rd_data, exp);
  endtask

  task automatic t_reset_state();
    check("R9", "wr_rsp_vld in reset", DW'(wr_rsp_vld), 32'd0);
    check("R9", "rd_rsp_vld in reset", DW'(rd_rsp_vld), 32'd0);
    check("R9", "rd_data in reset", rd_data, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    for (int k = 0; k < NR; k++) do_read("R9", AW'(4*k), 3'd2, 3'd0);
  endtask

  task automatic t_word_writes();
    do_write("R1", 8'h00, 32'h1111_0000, 4'hF, 3'd2, 3'd0);
    do_write("R1", 8'h04, 32'h2222_0101, 4'hF, 3'd2, 3'd0);
    do_write("R1", 8'h0B, 32'h3333_0202, 4'hF, 3'd2, 3'd0); // low bits ignored
    do_write("R1", 8'h0C, 32'h4444_0303, 4'hF, 3'd2, 3'd0);
    for (int k = 0; k < NR; k++) do_read("R1", AW'(4*k), 3'd2, 3'd0);
    @(negedge clk);
    check("R3", "wr_rsp_vld idle", DW'(wr_rsp_vld), 32'd0);
  endtask

  task automatic t_strobes();
    do_write("R2", 8'h08, 32'hAABB_CCDD, 4'b0101, 3'd2, 3'd0);
    do_read("R2", 8'h08, 3'd2, 3'd0);
    do_write("R2", 8'h09, 32'hEEEE_EEEE, 4'hF, 3'd0, 3'd0);   // byte lane 1 only
    do_read("R2", 8'h08, 3'd2, 3'd0);
    do_write("R2", 8'h0E, 32'h9988_7766, 4'hF, 3'd1, 3'd0);   // upper half only
    do_read("R2", 8'h0C, 3'd2, 3'd0);
    do_write("R2", 8'h00, 32'h5555_5555, 4'b0000, 3'd2, 3'd0); // no lanes
    do_read("R2", 8'h00, 3'd2, 3'd0);
  endtask

  task automatic t_out_of_range();
    do_write("R1", 8'h10, 32'hDEAD_BEEF, 4'hF, 3'd2, 3'd0);
    do_write("R1", 8'h40, 32'hDEAD_BEEF, 4'hF, 3'd2, 3'd0);
    for (int k = 0; k < NR; k++) do_read("R1", AW'(4*k), 3'd2, 3'd0);
    do_read("R7", 8'h20, 3'd2, 3'd0);
    do_read("R7", 8'hFC, 3'd2, 3'd0);
    do_read("R7", 8'h0A, 3'd0, 3'd0);   // narrow: only lane 2
    do_read("R7", 8'h06, 3'd1, 3'd0);   // narrow: upper half
  endtask

  task automatic t_read_during_write();
    logic [DW-1:0] old_v;
    old_v = model[1];
    @(negedge clk);
    wr_vld = 1'b1; wr_addr = 8'h04; wr_data = 32'h0BAD_F00D; wr_strb = 4'hF;
    wr_size = 3'd2; wr_prot = 3'd0;
    rd_vld = 1'b1; rd_addr = 8'h04; rd_size = 3'd2; rd_prot = 3'd0;
    @(negedge clk);
    wr_vld = 1'b0; rd_vld = 1'b0;
    check("R4", "read during write returns old", rd_data, old_v);
    check("R3", "wr_rsp_vld with concurrent read", DW'(wr_rsp_vld), 32'd1);
    model_write(8'h04, 32'h0BAD_F00D, 4'hF, 3'd2, 3'd0);
    do_read("R4", 8'h04, 3'd2, 3'd0);
  endtask

  task automatic t_back_to_back();
    @(negedge clk);
    rd_vld = 1'b1; rd_addr = 8'h00; rd_size = 3'd2; rd_prot = 3'd0;
    @(negedge clk);
    rd_addr = 8'h0C;
    check("R4", "first of pair", rd_data, model[0]);
    @(negedge clk);
    rd_vld = 1'b0;
    check("R4", "second of pair", rd_data, model[3]);
    check("R5", "rd_last on second", DW'(rd_last), 32'd1);
    @(negedge clk);
    check("R4", "rd_rsp_vld idle", DW'(rd_rsp_vld), 32'd0);
    check("R5", "rd_last idle", DW'(rd_last), 32'd0);
  endtask

  task automatic t_protection();
    do_write("R8", 8'h00, 32'hFFFF_0000, 4'hF, 3'd2, 3'b100); // dropped
    do_read("R8", 8'h00, 3'd2, 3'd0);
    do_write("R8", 8'h00, 32'h0123_4567, 4'hF, 3'd2, 3'b011); // not masked
    do_read("R8", 8'h00, 3'd2, 3'd0);
    do_read("R8", 8'h00, 3'd2, 3'b010);                        // blanked
    do_read("R8", 8'h00, 3'd2, 3'b101);                        // not masked
  endtask

  task automatic t_reset_again();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R9", "rd_data cleared", rd_data, 32'd0);
    rst_n = 1'b1;
    for (int k = 0; k < NR; k++) model[k] = '0;
    for (int k = 0; k < NR; k++) do_read("R9", AW'(4*k), 3'd2, 3'd0);
  endtask

  initial begin
    for (int k = 0; k < NR; k++) model[k] = '0;
    repeat (3) @(negedge clk);
    t_reset_state();
    t_word_writes();
    t_strobes();
    t_out_of_range();
    t_read_during_write();
    t_back_to_back();
    t_protection();
    t_reset_again();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule